// File: doc/BRIEF.md
# Spread Symbol Differential Encoder

This block is the front end of a differential four-phase spread-spectrum transmitter. A serial data bit stream is combined by exclusive-OR with a 31-chip maximal-length pseudo-noise sequence from a five-stage shift register. Each data bit may be stretched across several chips.

The spread chips are paired into two-bit absolute symbols. The first chip of each pair is the in-phase bit `a` and the second is the quadrature bit `b`. Each absolute symbol is then turned into a relative symbol `(c, d)` by modulo-4 accumulation onto the previous relative symbol, and the relative symbol drives the phase selection of a later carrier stage.

Chips advance only on cycles where the chip enable is high, so the block runs from a fast system clock at any chip rate up to one chip per clock. A symbol-valid strobe marks every completed pair.

Top module: `ssde_top`

## Requirements
- R1: While `clr_n` is low at a rising clock edge (synchronous clear), every output goes to 0 at that edge, the chip pairing restarts on the first chip, and the stored previous relative symbol becomes 00.
- R2: The pseudo-noise chip sequence after a clear is generated by a five-stage register for x^5 + x^2 + 1. It obeys p(n+5) = p(n) XOR p(n+3), its first five chips are 0,0,0,0,1, it repeats every 31 chips with 16 ones per period, and the register never holds all zeros (any such state is forced back to the seed).
- R3: Each spread chip equals the effective data bit XOR the pseudo-noise chip of the same step. Data 0 passes the chip unchanged, and data 1 inverts it.
- R4: With `CHIPS_PER_BIT` = N, `data_in` is sampled on the first chip of each group of N chips counted from the clear, and that value is used for all N chips of the group.
- R5: On a cycle with `chip_en` low, no output changes and the sequence does not advance.
- R6: Chips are paired in order from the clear. The first chip of a pair is `sym_a` and the second is `sym_b`, and the absolute symbol value is 2a+b.
- R7: The relative symbol value 2c+d equals (2a+b plus the previous relative symbol) mod 4. In bit form, d = b XOR d_prev and c = a XOR c_prev XOR (b AND d_prev).
- R8: `sym_valid` is high for exactly one cycle per completed pair and is never high on two consecutive cycles. `rel_c`/`rel_d` and `sym_a`/`sym_b` hold their values between strobes.
- R9: Outputs take a chip's effect at the rising edge where `chip_en` is sampled high: `pn_chip` and `spread_chip` change then, and `sym_valid` is high in the cycle after the enabled edge that completes a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Synchronous clear, active low |
| data_in | input | 1 | Serial data bit |
| chip_en | input | 1 | One-cycle chip step enable |
| pn_chip | output | 1 | Registered pseudo-noise chip |
| spread_chip | output | 1 | Registered data XOR pseudo-noise chip |
| sym_a | output | 1 | Absolute symbol, in-phase (first) bit |
| sym_b | output | 1 | Absolute symbol, quadrature (second) bit |
| rel_c | output | 1 | Relative symbol, high bit |
| rel_d | output | 1 | Relative symbol, low bit |
| sym_valid | output | 1 | One-cycle strobe on each new symbol |

## Verification
The assertions check on every cycle that the shift register never holds zero, that a low enable freezes the chip outputs, that every strobe follows an enabled edge and never repeats on the next cycle, that the relative symbol is steady between strobes, and that at each strobe the relative symbol equals the absolute symbol plus the last relative value modulo 4. Only the bench scenarios can show the exact chip sequence and its phase after a clear, the 31-chip period and its ones count, the inversion by data, the holding of a data bit across a chip group, and the odd/even pairing order. These properties depend on the history since the clear, and the bench tracks that history in its own model.

// File: rtl/ssde_pkg.sv
package ssde_pkg;

    // shift register geometry for x^5 + x^2 + 1
    localparam int unsigned PN_W    = 5;
    localparam int unsigned TAP_LO  = 1;           // stage 2
    localparam int unsigned TAP_HI  = PN_W - 1;    // stage 5
    localparam logic [PN_W-1:0] PN_SEED = 5'b00001;

    typedef struct packed {
        logic hi;   // first chip of a pair / c
        logic lo;   // second chip of a pair / d
    } dibit_t;

    function automatic logic [PN_W-1:0] pn_advance(input logic [PN_W-1:0] s);
        return {s[PN_W-2:0], s[TAP_HI] ^ s[TAP_LO]};
    endfunction

    // modulo-4 accumulate written with an explicit carry into the high bit
    function automatic dibit_t diff_step(input dibit_t absv, input dibit_t prev);
        dibit_t r;
        r.lo = absv.lo ^ prev.lo;
        r.hi = absv.hi ^ prev.hi ^ (absv.lo & prev.lo);
        return r;
    endfunction

endpackage

// File: rtl/ssde_pn_gen.sv
module ssde_pn_gen
    import ssde_pkg::*;
(
    input  logic            clk,
    input  logic            clr_n,
    input  logic            step,
    output logic [PN_W-1:0] state,
    output logic            pn_bit
);

    always_ff @(posedge clk) begin
        if (!clr_n || state == '0) begin
            state <= PN_SEED;
        end else if (step) begin
            state <= pn_advance(state);
        end
    end

    assign pn_bit = state[TAP_HI];

endmodule

// File: rtl/ssde_bit_stretch.sv
module ssde_bit_stretch #(
    parameter int unsigned CHIPS_PER_BIT = 1
) (
    input  logic clk,
    input  logic clr_n,
    input  logic step,
    input  logic data_in,
    output logic data_eff
);

    localparam int unsigned CNT_W = (CHIPS_PER_BIT > 1) ? $clog2(CHIPS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHIPS_PER_BIT - 1);

    logic [CNT_W-1:0] cnt;
    logic             held;

    always_ff @(posedge clk) begin
        if (!clr_n) begin
            cnt  <= '0;
            held <= 1'b0;
        end else if (step) begin
            if (cnt == '0) begin
                held <= data_in;
            end
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign data_eff = (cnt == '0) ? data_in : held;

endmodule

// File: rtl/ssde_pair_coder.sv
module ssde_pair_coder
    import ssde_pkg::*;
(
    input  logic   clk,
    input  logic   clr_n,
    input  logic   step,
    input  logic   chip,
    output dibit_t abs_sym,
    output dibit_t rel_sym,
    output logic   valid
);

    logic   second;     // next chip closes a pair
    logic   first_chip;
    dibit_t abs_next;

    assign abs_next = '{hi: first_chip, lo: chip};

    always_ff @(posedge clk) begin
        if (!clr_n) begin
            second     <= 1'b0;
            first_chip <= 1'b0;
            abs_sym    <= '0;
            rel_sym    <= '0;
            valid      <= 1'b0;
        end else begin
            valid <= step && second;
            if (step) begin
                second <= ~second;
                if (!second) begin
                    first_chip <= chip;
                end else begin
                    abs_sym <= abs_next;
                    rel_sym <= diff_step(abs_next, rel_sym);
                end
            end
        end
    end

endmodule

// File: rtl/ssde_top.sv
module ssde_top
    import ssde_pkg::*;
#(
    parameter int unsigned CHIPS_PER_BIT = 1
) (
    input  logic clk,
    input  logic clr_n,
    input  logic data_in,
    input  logic chip_en,
    output logic pn_chip,
    output logic spread_chip,
    output logic sym_a,
    output logic sym_b,
    output logic rel_c,
    output logic rel_d,
    output logic sym_valid
);

    logic [PN_W-1:0] pn_state;
    logic            pn_bit;
    logic            data_eff;
    logic            chip_now;
    dibit_t          abs_sym;
    dibit_t          rel_sym;

    ssde_pn_gen u_pn (
        .clk    (clk),
        .clr_n  (clr_n),
        .step   (chip_en),
        .state  (pn_state),
        .pn_bit (pn_bit)
    );

    ssde_bit_stretch #(.CHIPS_PER_BIT(CHIPS_PER_BIT)) u_stretch (
        .clk      (clk),
        .clr_n    (clr_n),
        .step     (chip_en),
        .data_in  (data_in),
        .data_eff (data_eff)
    );

    assign chip_now = data_eff ^ pn_bit;

    always_ff @(posedge clk) begin
        if (!clr_n) begin
            pn_chip     <= 1'b0;
            spread_chip <= 1'b0;
        end else if (chip_en) begin
            pn_chip     <= pn_bit;
            spread_chip <= chip_now;
        end
    end

    ssde_pair_coder u_pair (
        .clk     (clk),
        .clr_n   (clr_n),
        .step    (chip_en),
        .chip    (chip_now),
        .abs_sym (abs_sym),
        .rel_sym (rel_sym),
        .valid   (sym_valid)
    );

    assign sym_a = abs_sym.hi;
    assign sym_b = abs_sym.lo;
    assign rel_c = rel_sym.hi;
    assign rel_d = rel_sym.lo;

endmodule

// File: rtl/ssde_chk.sv
module ssde_chk
    import ssde_pkg::*;
(
    input logic            clk,
    input logic            clr_n,
    input logic            chip_en,
    input logic            pn_chip,
    input logic            spread_chip,
    input logic            sym_a,
    input logic            sym_b,
    input logic            rel_c,
    input logic            rel_d,
    input logic            sym_valid,
    input logic [PN_W-1:0] pn_state
);

    logic [1:0] last_rel;

    always_ff @(posedge clk) begin
        if (!clr_n) begin
            last_rel <= 2'b00;
        end else if (sym_valid) begin
            last_rel <= {rel_c, rel_d};
        end
    end

    // R2
    pn_nonzero_chk: assert property (@(posedge clk) disable iff (!clr_n)
        pn_state != '0);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !chip_en |=> ($stable(pn_chip) && $stable(spread_chip)));

    // R7
    mod4_sum_chk: assert property (@(posedge clk) disable iff (!clr_n)
        sym_valid |-> ({rel_c, rel_d} == 2'({sym_a, sym_b} + last_rel)));

    // R8
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!clr_n)
        sym_valid |=> !sym_valid);

    // R8
    rel_steady_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !sym_valid |-> $stable({rel_c, rel_d}));

    // R9
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!clr_n)
        sym_valid |-> $past(chip_en));

endmodule

bind ssde_top ssde_chk u_chk (
    .clk         (clk),
    .clr_n       (clr_n),
    .chip_en     (chip_en),
    .pn_chip     (pn_chip),
    .spread_chip (spread_chip),
    .sym_a       (sym_a),
    .sym_b       (sym_b),
    .rel_c       (rel_c),
    .rel_d       (rel_d),
    .sym_valid   (sym_valid),
    .pn_state    (pn_state)
);

// File: tb/ssde_top_test.sv
module ssde_top_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic clr_n, data_in, chip_en;
    logic pn_chip, spread_chip, sym_a, sym_b, rel_c, rel_d, sym_valid;
    logic h_pn, h_sp, h_a, h_b, h_c, h_d, h_v;

    ssde_top uut (
        .clk(clk), .clr_n(clr_n), .data_in(data_in), .chip_en(chip_en),
        .pn_chip(pn_chip), .spread_chip(spread_chip), .sym_a(sym_a), .sym_b(sym_b),
        .rel_c(rel_c), .rel_d(rel_d), .sym_valid(sym_valid)
    );

    ssde_top #(.CHIPS_PER_BIT(3)) uut_hold (
        .clk(clk), .clr_n(clr_n), .data_in(data_in), .chip_en(chip_en),
        .pn_chip(h_pn), .spread_chip(h_sp), .sym_a(h_a), .sym_b(h_b),
        .rel_c(h_c), .rel_d(h_d), .sym_valid(h_v)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    bit pn_ref [31];
    int k, phase, cnt3, ones;
    bit a_ref, hold3, e_pn, e_sp, e_sp3, e_v;
    logic [1:0] abs_ref, rel_ref;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic void build_ref();
        // R2: seed gives 0,0,0,0,1 then p(n+5) = p(n) ^ p(n+3)
        for (int i = 0; i < 5; i++) pn_ref[i] = (i == 4);
        for (int i = 0; i + 5 < 31; i++) pn_ref[i+5] = pn_ref[i] ^ pn_ref[i+3];
    endfunction

    task automatic do_clear();
        @(negedge clk);
        clr_n = 1'b0; chip_en = 1'b0; data_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        k = 0; phase = 0; cnt3 = 0; hold3 = 0; a_ref = 0;
        abs_ref = 2'b00; rel_ref = 2'b00;
        e_pn = 0; e_sp = 0; e_sp3 = 0; e_v = 0;
        // R1: state seen while clear is held
        check("R1 pn", pn_chip, 0);
        check("R1 spread", spread_chip, 0);
        check("R1 abs", {sym_a, sym_b}, 0);
        check("R1 rel", {rel_c, rel_d}, 0);
        check("R1 valid", sym_valid, 0);
        clr_n = 1'b1;
    endtask

    task automatic step(input bit ce, input bit d);
        bit eff3;
        chip_en = ce; data_in = d;
        e_v = 0;
        if (ce) begin
            e_pn = pn_ref[k];
            e_sp = pn_ref[k] ^ d;
            eff3 = (cnt3 == 0) ? d : hold3;
            if (cnt3 == 0) hold3 = d;
            cnt3 = (cnt3 == 2) ? 0 : cnt3 + 1;
            e_sp3 = pn_ref[k] ^ eff3;
            k = (k + 1) % 31;
            if (phase == 0) begin
                a_ref = e_sp;
            end else begin
                abs_ref = {a_ref, e_sp};
                rel_ref = 2'(abs_ref + rel_ref);
                e_v = 1;
            end
            phase ^= 1;
        end
        @(posedge clk);
        @(negedge clk);
        check("R2 pn chip", pn_chip, e_pn);
        check("R3 spread chip", spread_chip, e_sp);
        check("R4 stretched chip", h_sp, e_sp3);
        check("R9 valid timing", sym_valid, e_v);
        check("R6 absolute symbol", {sym_a, sym_b}, abs_ref);
        check("R7 relative symbol", {rel_c, rel_d}, rel_ref);
        if (!ce) check("R5 idle no change", {pn_chip, spread_chip}, {e_pn, e_sp});
        if (ce && e_pn) ones++;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        build_ref();
        clr_n = 1'b0; chip_en = 1'b0; data_in = 1'b0;
        do_clear();

        // R2 R3: one full period with data 0, chip equals PN
        ones = 0;
        for (int i = 0; i < 31; i++) step(1'b1, 1'b0);
        check("R2 ones per period", 8'(ones), 16);
        // R3: data 1 inverts, second period also checks the 31-chip repeat
        for (int i = 0; i < 31; i++) step(1'b1, 1'b1);

        // R5: long idle gap, nothing moves
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1);

        // R8: enable on every cycle, strobes alternate
        for (int i = 0; i < 20; i++) step(1'b1, 1'($urandom_range(0, 1)));

        // R1: clear in the middle of a pair restarts pairing and the sequence
        step(1'b1, 1'b1);
        do_clear();
        for (int i = 0; i < 12; i++) step(1'b1, 1'($urandom_range(0, 1)));

        // random mix of enables and data
        for (int i = 0; i < 3000; i++)
            step(1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 1)));

        // R4: data toggling every chip, stretched instance keeps group value
        do_clear();
        for (int i = 0; i < 30; i++) step(1'b1, 1'(i % 2));

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule